// File: doc/BRIEF.md
# Redundant Controller Failover Watchdog

This block sits in the power-switching logic and keeps one of two redundant system controllers powered at any moment. The powered controller shows it is alive by writing a fixed key to a fixed address on the peripheral control bus. Each such write restarts a down-counter that advances on a slow tick enable. The tick is a 1 Hz enable by default, so the default timeout is 90 s.

If the counter runs out, the block takes power away from the running controller. It then waits a fixed number of ticks with both controllers dark, powers the other controller and gives it a full fresh timeout. Every later timeout swaps again, so the two units alternate for as long as the fault persists. This also covers a controller that stops kicking on purpose, for example after an uncorrectable memory error.

A ground command pulse forces the same swap at once. A swap counter and an active-unit flag are brought out at the ports.

Top module: `ctl_failover_wdt`

## Requirements
- R1: After reset, unit A is powered (`pwr_en_a`=1), unit B is off, `active_b` is 0 and `swap_cnt` is 0.
- R2: While a unit is running, a bus write with `bus_addr`=KICK_ADDR and `bus_wdata`=KICK_KEY restarts the timeout at TIMEOUT_TICKS ticks, so the unit stays powered while kicks come fewer than TIMEOUT_TICKS ticks apart.
- R3: The timeout advances only on cycles where `tick_en` is 1. On the TIMEOUT_TICKS-th tick with no kick, both power enables are 0 from the next cycle on.
- R4: After a further GAP_TICKS ticks, the other unit's enable goes to 1, `active_b` toggles and `swap_cnt` increments, wrapping to 0 after 2^SWAP_W swaps.
- R5: The two enables are never 1 together, and both are 0 for the whole gap.
- R6: A bus write whose address or whose data differs from the kick values does not restart the timeout.
- R7: A one-cycle pulse on `force_swap` while a unit is running starts the gap in the next cycle, whatever the timeout count is.
- R8: Kicks and `force_swap` during the gap have no effect, and the gap still ends after exactly GAP_TICKS ticks.
- R9: Repeated timeouts alternate the powered unit: A, then B, then A again.
- R10: The newly powered unit gets a full TIMEOUT_TICKS ticks, counted from the end of the swap.
- R11: A kick in the same cycle as the expiring tick wins and no swap starts. A `force_swap` in the same cycle as a kick wins and the gap starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick enable, one cycle per tick |
| bus_wr | input | 1 | Peripheral bus write strobe |
| bus_addr | input | ADDR_W | Peripheral bus write address |
| bus_wdata | input | DATA_W | Peripheral bus write data |
| force_swap | input | 1 | Ground command pulse that forces a swap |
| pwr_en_a | output | 1 | Power enable for controller A |
| pwr_en_b | output | 1 | Power enable for controller B |
| active_b | output | 1 | 1 when controller B is the selected unit |
| swap_cnt | output | SWAP_W | Number of completed swaps, wrapping |

## Verification
A timeout counter that is off by one shows as power dropping one tick early or late, and the bench sees it at the first expiry after reset, before any swap. A wrong sequencer state shows as the wrong unit powered, or as both units dark for longer or shorter than GAP_TICKS ticks, within one swap. A fault in the kick decode or in the kick priority shows as a swap that should not happen, or one that is missing, at most one timeout period after the bad kick. A swap counter that wraps wrongly shows only after 2^SWAP_W swaps, so the bench runs that many.

// File: rtl/wdt_failover_pkg.sv
package wdt_failover_pkg;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_GAP = 1'b1
  } fo_state_e;

  // number of bits needed to hold a count of 0..n
  function automatic int count_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // unit selected after a completed swap
  function automatic logic next_unit(input logic cur_b);
    return ~cur_b;
  endfunction

  // kick recognition: both address and key must match
  function automatic logic kick_match(input logic [31:0] addr, input logic [31:0] exp_addr,
                                      input logic [31:0] data, input logic [31:0] exp_key);
    return (addr == exp_addr) && (data == exp_key);
  endfunction

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expire
);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = run && tick && !load;
  // the last tick of a window; a load in the same cycle wins
  assign expire = step && (cnt_q == W'(1));
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= W'(RST_VAL);
    else if (load)                   cnt_q <= load_val;
    else if (step && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt)); // R3

endmodule

// File: rtl/wdt_bus_kick.sv
module wdt_bus_kick #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter logic [31:0] KICK_ADDR = 32'h2C,
  parameter logic [31:0] KICK_KEY  = 32'hA5C3
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              kick_hit
);
  import wdt_failover_pkg::*;

  localparam logic [31:0] ADDR_MASK = (ADDR_W >= 32) ? '1 : ((32'd1 << ADDR_W) - 32'd1);
  localparam logic [31:0] DATA_MASK = (DATA_W >= 32) ? '1 : ((32'd1 << DATA_W) - 32'd1);

  assign kick_hit = bus_wr && kick_match(32'(bus_addr), KICK_ADDR & ADDR_MASK,
                                         32'(bus_wdata), KICK_KEY & DATA_MASK);
endmodule

// File: rtl/wdt_swap_seq.sv
module wdt_swap_seq #(
  parameter int SWAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_req,
  input  logic              wd_expire,
  input  logic              gap_done,
  output logic              swap_req,
  output logic              in_gap,
  output logic              active_b,
  output logic [SWAP_W-1:0] swap_cnt,
  output logic              pwr_en_a,
  output logic              pwr_en_b
);
  import wdt_failover_pkg::*;

  fo_state_e         state_q;
  logic              act_q;
  logic [SWAP_W-1:0] swaps_q;

  assign in_gap   = (state_q == ST_GAP);
  assign swap_req = !in_gap && (force_req || wd_expire);
  assign pwr_en_a = !in_gap && !act_q;
  assign pwr_en_b = !in_gap && act_q;
  assign active_b = act_q;
  assign swap_cnt = swaps_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      act_q   <= 1'b0;
      swaps_q <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (swap_req) state_q <= ST_GAP;
        ST_GAP: if (gap_done) begin
          state_q <= ST_RUN;
          act_q   <= next_unit(act_q);
          swaps_q <= swaps_q + SWAP_W'(1);
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  AST_ONE_UNIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_en_a && pwr_en_b)); // R5
  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |=> (!pwr_en_a && !pwr_en_b)); // R5
  AST_SWAP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && gap_done) |=> (active_b != $past(active_b))); // R4
  AST_SWAP_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && gap_done) |=> (swap_cnt == $past(swap_cnt) + SWAP_W'(1))); // R4
  AST_FORCE_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_gap && force_req) |=> in_gap); // R7
  AST_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !gap_done |=> $stable(active_b)); // R9

endmodule

// File: rtl/ctl_failover_wdt.sv
module ctl_failover_wdt #(
  parameter int          ADDR_W        = 8,
  parameter int          DATA_W        = 16,
  parameter logic [31:0] KICK_ADDR     = 32'h2C,
  parameter logic [31:0] KICK_KEY      = 32'hA5C3,
  parameter int          TIMEOUT_TICKS = 90,
  parameter int          GAP_TICKS     = 4,
  parameter int          SWAP_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              force_swap,
  output logic              pwr_en_a,
  output logic              pwr_en_b,
  output logic              active_b,
  output logic [SWAP_W-1:0] swap_cnt
);
  import wdt_failover_pkg::*;

  localparam int WD_W  = count_bits(TIMEOUT_TICKS);
  localparam int GAP_W = count_bits(GAP_TICKS);
  localparam logic [WD_W-1:0]  WD_RELOAD  = WD_W'(TIMEOUT_TICKS);
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(GAP_TICKS);

  // named internal events
  logic             kick_hit;
  logic             kick_ok;
  logic             wd_expire;
  logic             gap_done;
  logic             swap_req;
  logic             in_gap;
  logic [WD_W-1:0]  wd_cnt;
  logic [GAP_W-1:0] gap_cnt;

  wdt_bus_kick #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KICK_ADDR(KICK_ADDR), .KICK_KEY(KICK_KEY)
  ) u_kick (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .kick_hit(kick_hit)
  );

  assign kick_ok = kick_hit && !in_gap;

  wdt_tick_counter #(.W(WD_W), .RST_VAL(TIMEOUT_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .load(kick_ok || gap_done), .load_val(WD_RELOAD),
    .run(!in_gap), .tick(tick_en),
    .cnt(wd_cnt), .expire(wd_expire)
  );

  wdt_tick_counter #(.W(GAP_W), .RST_VAL(0)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(swap_req), .load_val(GAP_RELOAD),
    .run(in_gap), .tick(tick_en),
    .cnt(gap_cnt), .expire(gap_done)
  );

  wdt_swap_seq #(.SWAP_W(SWAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .force_req(force_swap), .wd_expire(wd_expire), .gap_done(gap_done),
    .swap_req(swap_req), .in_gap(in_gap),
    .active_b(active_b), .swap_cnt(swap_cnt),
    .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b)
  );

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt <= WD_RELOAD); // R2
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GAP_RELOAD); // R8
  AST_GAP_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && !gap_done) |=> in_gap); // R8
  AST_KICK_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_ok && !force_swap) |=> !in_gap); // R11
  AST_FRESH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |=> (wd_cnt == WD_RELOAD)); // R10

endmodule

// File: tb/sim_ctl_failover_wdt.sv
module sim_ctl_failover_wdt;

  localparam int T_OUT = 10;
  localparam int T_GAP = 3;
  localparam logic [7:0]  K_ADDR = 8'h2C;
  localparam logic [15:0] K_KEY  = 16'hA5C3;

  localparam logic [2:0] OP_TICK = 3'd0, OP_KICK = 3'd1, OP_BADA = 3'd2,
                         OP_BADD = 3'd3, OP_FORCE = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] n;
    logic       ea;
    logic       eb;
    logic       eact;
    logic [7:0] ecnt;
    logic [7:0] req;
  } vec_t;

  // op, count, expected a, b, active_b, swap count, requirement number
  localparam vec_t VEC [15] = '{
    '{OP_TICK, 8'd9, 1'b1, 1'b0, 1'b0, 8'd0, 8'd3},  // R3 not yet expired
    '{OP_KICK, 8'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'd2},  // R2
    '{OP_TICK, 8'd9, 1'b1, 1'b0, 1'b0, 8'd0, 8'd2},  // R2 reload held
    '{OP_BADA, 8'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'd6},  // R6
    '{OP_TICK, 8'd1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd6},  // R6 R3 expiry
    '{OP_TICK, 8'd2, 1'b0, 1'b0, 1'b0, 8'd0, 8'd5},  // R5
    '{OP_KICK, 8'd1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd8},  // R8
    '{OP_FORCE,8'd1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd8},  // R8
    '{OP_TICK, 8'd1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd4},  // R4
    '{OP_TICK, 8'd9, 1'b0, 1'b1, 1'b1, 8'd1, 8'd10}, // R10
    '{OP_BADD, 8'd1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd6},  // R6
    '{OP_TICK, 8'd1, 1'b0, 1'b0, 1'b1, 8'd1, 8'd6},  // R6
    '{OP_TICK, 8'd3, 1'b1, 1'b0, 1'b0, 8'd2, 8'd9},  // R9
    '{OP_FORCE,8'd1, 1'b0, 1'b0, 1'b0, 8'd2, 8'd7},  // R7
    '{OP_TICK, 8'd3, 1'b0, 1'b1, 1'b1, 8'd3, 8'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        force_swap = 1'b0;
  logic        pwr_en_a, pwr_en_b, active_b;
  logic [7:0]  swap_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctl_failover_wdt #(
    .ADDR_W(8), .DATA_W(16), .KICK_ADDR(32'(K_ADDR)), .KICK_KEY(32'(K_KEY)),
    .TIMEOUT_TICKS(T_OUT), .GAP_TICKS(T_GAP), .SWAP_W(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .force_swap(force_swap),
    .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b), .active_b(active_b), .swap_cnt(swap_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic ea, input logic eb,
                         input logic eact, input int ecnt);
    chk({tag, " pwr_en_a"}, int'(pwr_en_a), int'(ea));
    chk({tag, " pwr_en_b"}, int'(pwr_en_b), int'(eb));
    chk({tag, " active_b"}, int'(active_b), int'(eact));
    chk({tag, " swap_cnt"}, int'(swap_cnt), ecnt);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic with_tick,
                           input logic with_force);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick_en = with_tick; force_swap = with_force;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0; force_swap = 1'b0;
  endtask

  task automatic force_pulse();
    @(negedge clk) force_swap = 1'b1;
    @(negedge clk) force_swap = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_all("R1 reset", 1'b1, 1'b0, 1'b0, 0);

    foreach (VEC[i]) begin
      case (VEC[i].op)
        OP_TICK:  ticks(int'(VEC[i].n));
        OP_KICK:  bus_write(K_ADDR, K_KEY, 1'b0, 1'b0);
        OP_BADA:  bus_write(K_ADDR ^ 8'h01, K_KEY, 1'b0, 1'b0);
        OP_BADD:  bus_write(K_ADDR, K_KEY ^ 16'h0100, 1'b0, 1'b0);
        default:  force_pulse();
      endcase
      chk_all($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ea, VEC[i].eb,
              VEC[i].eact, int'(VEC[i].ecnt));
    end

    // R11: kick on the expiring tick keeps unit B running
    ticks(T_OUT - 1);
    bus_write(K_ADDR, K_KEY, 1'b1, 1'b0);
    chk_all("R11 kick on last tick", 1'b0, 1'b1, 1'b1, 3);
    ticks(T_OUT - 1);
    chk_all("R11 full window after kick", 1'b0, 1'b1, 1'b1, 3);
    ticks(1);
    chk_all("R11 expiry after kick window", 1'b0, 1'b0, 1'b1, 3);
    ticks(T_GAP);
    chk_all("R9 back to A", 1'b1, 1'b0, 1'b0, 4);

    // R11: force beats a simultaneous kick
    bus_write(K_ADDR, K_KEY, 1'b0, 1'b1);
    chk_all("R11 force with kick", 1'b0, 1'b0, 1'b0, 4);
    ticks(T_GAP);
    chk_all("R7 swap after force", 1'b0, 1'b1, 1'b1, 5);

    // R3: no tick, no counting
    repeat (3 * T_OUT) @(negedge clk);
    chk_all("R3 idle without tick", 1'b0, 1'b1, 1'b1, 5);

    // R4: swap counter wraps after 256 swaps
    for (int s = 5; s < 256; s++) begin
      force_pulse();
      ticks(T_GAP);
      if (s == 254) chk_all("R4 count 255", 1'b0, 1'b1, 1'b1, 255);
    end
    chk_all("R4 wrap to zero", 1'b1, 1'b0, 1'b0, 0);

    // R1: reset in the middle of a gap
    force_pulse();
    do_reset();
    chk_all("R1 reset mid gap", 1'b1, 1'b0, 1'b0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule